// File: doc/BRIEF.md
# Static Branch Direction and Speculation Flush Unit

This block sits beside a fetch stage and decides a direction for each decoded branch presented to it. The decision is a fixed rule. It uses the kind of branch, the sign of its displacement, whether a register-held target is ready, and a per-instruction hint bit that reverses the default guess. A branch whose condition is already known is resolved at once and does not go through the rule. A register-target branch whose target is not ready gets a wait outcome and must be presented again.

Only one predicted branch may be unresolved at a time. While it is unresolved the block raises a speculative tag, which fetch attaches to every instruction it fetches. When the execution side reports the branch outcome, a correct guess drops the tag one cycle later. A wrong guess also drops the tag and, in the same cycle, pulses a flush together with a redirect address: the fall-through address if the guess was taken, the branch target if the guess was fall-through. The fetch stage supplies both addresses with the branch, so no address arithmetic is done here.

Top module: `brpred_unit`

## Requirements
- R1: For kind 2'b00 (conditional, PC-relative displacement) with `cond_known_i`=0, `pred_dir_o` is 2'b01 (taken) when the displacement is negative and the hint is 0, or positive and the hint is 1; otherwise it is 2'b00 (fall-through).
- R2: For kind 2'b01 (target held in link or count register) with the target ready and `cond_known_i`=0, the direction is taken when the hint is 1 and fall-through when it is 0.
- R3: For kind 2'b01 with `tgt_ready_i`=0, the direction is 2'b10 (wait) and `stall_o` is 1 whatever the hint and condition inputs are, and no speculation starts.
- R4: Kinds 2'b10 (unconditional) and 2'b11 are always taken, flagged resolved, never stalled and never start speculation.
- R5: With `cond_known_i`=1 (and, for kind 2'b01, the target ready), `pred_resolved_o` is 1, the direction equals `cond_taken_i`, and no speculation starts.
- R6: An accepted branch that needs a prediction raises `spec_o` from the next cycle until its outcome is reported.
- R7: While `spec_o` is 1, a further branch that would need a prediction is stalled (`stall_o`=1) and not accepted.
- R8: When an outcome arrives on `res_valid_i` while `spec_o` is 1 and differs from the guess, `flush_o` and `redir_valid_o` are 1 in the next cycle with `redir_addr_o` set to the fall-through address for a taken guess and the target for a fall-through guess; `spec_o` is 0 in that cycle.
- R9: A matching outcome drops `spec_o` in the next cycle with no flush.
- R10: `res_valid_i` while `spec_o` is 0 has no effect: no flush follows.
- R11: After reset `spec_o`, `flush_o` and `redir_valid_o` are 0.
- R12: `flush_o` never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| br_valid_i | input | 1 | A decoded branch is presented |
| br_kind_i | input | 2 | Branch kind: 00 conditional displacement, 01 register target, 10/11 unconditional |
| disp_neg_i | input | 1 | Displacement sign is negative |
| hint_i | input | 1 | Reverses the default guess |
| cond_known_i | input | 1 | Condition is available at issue |
| cond_taken_i | input | 1 | Known condition outcome |
| tgt_ready_i | input | 1 | Register-held target is ready |
| fall_addr_i | input | AW | Fall-through address of the branch |
| targ_addr_i | input | AW | Target address of the branch |
| res_valid_i | input | 1 | Outcome of the outstanding branch is reported |
| res_taken_i | input | 1 | Reported outcome is taken |
| pred_dir_o | output | 2 | Direction: 00 fall-through, 01 taken, 10 wait |
| pred_resolved_o | output | 1 | Direction comes from a known condition |
| stall_o | output | 1 | Branch not accepted this cycle |
| spec_o | output | 1 | Fetched instructions are speculative |
| flush_o | output | 1 | One-cycle flush of speculative instructions |
| redir_valid_o | output | 1 | Redirect address is valid |
| redir_addr_o | output | AW | Address to refetch from |

## Verification
A corrupted guess bit or stored redirect address stays hidden until the outcome arrives, then shows in the cycle after `res_valid_i` as a missing or spurious flush or a wrong `redir_addr_o`. A stuck occupancy flag shows at once as `spec_o` staying high or low and, on the next branch needing a guess, as a wrong `stall_o`. The bench compares every port against a behavioural model each cycle, so such a fault is reported within one cycle of becoming visible.

// File: rtl/brpred_pkg.sv
package brpred_pkg;

   typedef enum logic [1:0] {
      K_CDISP = 2'b00,
      K_REGT  = 2'b01,
      K_JUMP  = 2'b10,
      K_RSVD  = 2'b11
   } br_kind_e;

   typedef enum logic [1:0] {
      D_FALL  = 2'b00,
      D_TAKEN = 2'b01,
      D_WAIT  = 2'b10
   } br_dir_e;

   function automatic br_dir_e dir_of(input logic taken);
      return taken ? D_TAKEN : D_FALL;
   endfunction

endpackage

// File: rtl/brpred_rule.sv
module brpred_rule
   import brpred_pkg::*;
#(
   parameter bit HINT_EN = 1'b1
) (
   input  logic [1:0] kind_i,
   input  logic       disp_neg_i,
   input  logic       hint_i,
   input  logic       tgt_ready_i,
   input  logic       cond_known_i,
   input  logic       cond_taken_i,
   output logic [1:0] dir_o,
   output logic       resolved_o,
   output logic       needs_slot_o
);

   logic    eff_hint;
   br_dir_e dir;

   generate
      if (HINT_EN) begin : g_hint
         assign eff_hint = hint_i;
      end else begin : g_nohint
         logic unused_hint;
         assign unused_hint = hint_i;
         assign eff_hint    = 1'b0;
      end
   endgenerate

   always_comb begin
      dir          = D_TAKEN;
      resolved_o   = 1'b1;
      needs_slot_o = 1'b0;
      unique case (br_kind_e'(kind_i))
         K_CDISP: begin
            if (cond_known_i) begin
               dir = dir_of(cond_taken_i);
            end else begin
               dir          = dir_of(disp_neg_i ^ eff_hint);
               resolved_o   = 1'b0;
               needs_slot_o = 1'b1;
            end
         end
         K_REGT: begin
            if (!tgt_ready_i) begin
               dir        = D_WAIT;
               resolved_o = 1'b0;
            end else if (cond_known_i) begin
               dir = dir_of(cond_taken_i);
            end else begin
               dir          = dir_of(eff_hint);
               resolved_o   = 1'b0;
               needs_slot_o = 1'b1;
            end
         end
         default: begin
            dir = D_TAKEN;
         end
      endcase
   end

   assign dir_o = dir;

endmodule

// File: rtl/brpred_slot.sv
module brpred_slot #(
   parameter int AW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          accept_i,
   input  logic          ptaken_i,
   input  logic [AW-1:0] fall_addr_i,
   input  logic [AW-1:0] targ_addr_i,
   input  logic          res_valid_i,
   input  logic          res_taken_i,
   output logic          busy_o,
   output logic          mispred_o,
   output logic [AW-1:0] fix_addr_o
);

   logic          busy_q;
   logic          ptaken_q;
   logic [AW-1:0] alt_q;
   logic          resolve;

   assign resolve = busy_q & res_valid_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q   <= 1'b0;
         ptaken_q <= 1'b0;
         alt_q    <= '0;
      end else begin
         if (resolve) begin
            busy_q <= 1'b0;
         end else if (accept_i) begin
            busy_q   <= 1'b1;
            ptaken_q <= ptaken_i;
            alt_q    <= ptaken_i ? fall_addr_i : targ_addr_i;
         end
      end
   end

   assign busy_o     = busy_q;
   assign mispred_o  = resolve & (res_taken_i != ptaken_q);
   assign fix_addr_o = alt_q;

endmodule

// File: rtl/brpred_flush.sv
module brpred_flush #(
   parameter int AW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          mispred_i,
   input  logic [AW-1:0] fix_addr_i,
   output logic          flush_o,
   output logic [AW-1:0] redir_addr_o
);

   logic          flush_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         flush_q <= 1'b0;
         addr_q  <= '0;
      end else begin
         flush_q <= mispred_i;
         if (mispred_i) begin
            addr_q <= fix_addr_i;
         end
      end
   end

   assign flush_o      = flush_q;
   assign redir_addr_o = addr_q;

endmodule

// File: rtl/brpred_unit.sv
module brpred_unit
   import brpred_pkg::*;
#(
   parameter int AW      = 32,
   parameter bit HINT_EN = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          br_valid_i,
   input  logic [1:0]    br_kind_i,
   input  logic          disp_neg_i,
   input  logic          hint_i,
   input  logic          cond_known_i,
   input  logic          cond_taken_i,
   input  logic          tgt_ready_i,
   input  logic [AW-1:0] fall_addr_i,
   input  logic [AW-1:0] targ_addr_i,
   input  logic          res_valid_i,
   input  logic          res_taken_i,
   output logic [1:0]    pred_dir_o,
   output logic          pred_resolved_o,
   output logic          stall_o,
   output logic          spec_o,
   output logic          flush_o,
   output logic          redir_valid_o,
   output logic [AW-1:0] redir_addr_o
);

   initial begin
      if (AW < 2) $fatal(1, "brpred_unit: AW must be at least 2");
   end

   logic [1:0]    dir;
   logic          resolved;
   logic          needs_slot;
   logic          busy;
   logic          mispred;
   logic [AW-1:0] fix_addr;
   logic          accept;
   logic          is_wait;
   logic          flush;

   brpred_rule #(.HINT_EN(HINT_EN)) u_rule (
      .kind_i       (br_kind_i),
      .disp_neg_i   (disp_neg_i),
      .hint_i       (hint_i),
      .tgt_ready_i  (tgt_ready_i),
      .cond_known_i (cond_known_i),
      .cond_taken_i (cond_taken_i),
      .dir_o        (dir),
      .resolved_o   (resolved),
      .needs_slot_o (needs_slot)
   );

   assign is_wait = (dir == D_WAIT);
   assign stall_o = br_valid_i & (is_wait | (needs_slot & busy));
   assign accept  = br_valid_i & needs_slot & ~busy;

   brpred_slot #(.AW(AW)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .accept_i    (accept),
      .ptaken_i    (dir == D_TAKEN),
      .fall_addr_i (fall_addr_i),
      .targ_addr_i (targ_addr_i),
      .res_valid_i (res_valid_i),
      .res_taken_i (res_taken_i),
      .busy_o      (busy),
      .mispred_o   (mispred),
      .fix_addr_o  (fix_addr)
   );

   brpred_flush #(.AW(AW)) u_flush (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .mispred_i    (mispred),
      .fix_addr_i   (fix_addr),
      .flush_o      (flush),
      .redir_addr_o (redir_addr_o)
   );

   assign pred_dir_o      = dir;
   assign pred_resolved_o = resolved;
   assign spec_o          = busy;
   assign flush_o         = flush;
   assign redir_valid_o   = flush;

endmodule

// File: rtl/brpred_chk.sv
module brpred_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       br_valid_i,
   input logic [1:0] br_kind_i,
   input logic       cond_known_i,
   input logic       tgt_ready_i,
   input logic       res_valid_i,
   input logic [1:0] pred_dir_o,
   input logic       stall_o,
   input logic       spec_o,
   input logic       flush_o
);

   p_wait_stalls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_valid_i && br_kind_i == 2'b01 && !tgt_ready_i) |-> (stall_o && pred_dir_o == 2'b10));

   p_jump_taken_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_valid_i && br_kind_i[1]) |-> (pred_dir_o == 2'b01 && !stall_o));

   p_spec_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_valid_i && !stall_o && !cond_known_i && !br_kind_i[1] && !spec_o) |=> spec_o);

   p_busy_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spec_o && br_valid_i && !cond_known_i && br_kind_i == 2'b00) |-> stall_o);

   p_flush_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spec_o && res_valid_i) |=> !spec_o);

   p_idle_res_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!spec_o) |=> !flush_o);

   p_flush_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |=> !flush_o);

endmodule

bind brpred_unit brpred_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .br_valid_i   (br_valid_i),
   .br_kind_i    (br_kind_i),
   .cond_known_i (cond_known_i),
   .tgt_ready_i  (tgt_ready_i),
   .res_valid_i  (res_valid_i),
   .pred_dir_o   (pred_dir_o),
   .stall_o      (stall_o),
   .spec_o       (spec_o),
   .flush_o      (flush_o)
);

// File: tb/tb_brpred_unit.sv
module tb_brpred_unit;

   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          v, ng, h, ck, ct, tr, rv, rt;
   logic [1:0]    k;
   logic [AW-1:0] fa, ta;
   logic [1:0]    dir;
   logic          resd, stall, spec, flush, rvalid;
   logic [AW-1:0] raddr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural reference state
   bit          m_busy = 0;
   bit          m_ptaken = 0;
   logic [AW-1:0] m_alt = '0;
   bit          m_flush = 0;
   logic [AW-1:0] m_raddr = '0;

   always #4 clk = ~clk;

   brpred_unit #(.AW(AW)) dut (
      .clk_i(clk), .rst_ni(rst_n), .br_valid_i(v), .br_kind_i(k),
      .disp_neg_i(ng), .hint_i(h), .cond_known_i(ck), .cond_taken_i(ct),
      .tgt_ready_i(tr), .fall_addr_i(fa), .targ_addr_i(ta),
      .res_valid_i(rv), .res_taken_i(rt), .pred_dir_o(dir),
      .pred_resolved_o(resd), .stall_o(stall), .spec_o(spec),
      .flush_o(flush), .redir_valid_o(rvalid), .redir_addr_o(raddr)
   );

   task automatic chk(input string req, input string what,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // expected direction: 0 fall, 1 taken, 2 wait; res = resolved; nd = needs guess
   task automatic model_dir(output int d, output bit res, output bit nd, output string tg);
      nd = 0; res = 1;
      if (k == 2'b10 || k == 2'b11) begin
         d = 1; tg = "R4";
      end else if (k == 2'b01 && !tr) begin
         d = 2; res = 0; tg = "R3";
      end else if (ck) begin
         d = ct ? 1 : 0; tg = "R5";
      end else if (k == 2'b00) begin
         res = 0; nd = 1; tg = "R1";
         if (ng && !h) d = 1;
         else if (ng && h) d = 0;
         else if (!ng && !h) d = 0;
         else d = 1;
      end else begin
         res = 0; nd = 1; tg = "R2";
         d = h ? 1 : 0;
      end
   endtask

   task automatic step(input string tg);
      int d; bit res, nd; string dt;
      bit exp_stall, accept, fl_n;
      #1;
      model_dir(d, res, nd, dt);
      exp_stall = v && (d == 2 || (nd && m_busy));
      if (v) begin
         chk(dt, "pred_dir", AW'(dir), AW'(d));
         chk(dt, "resolved", AW'(resd), AW'(res));
      end
      chk((nd && m_busy) ? "R7" : "R3", "stall", AW'(stall), AW'(exp_stall));
      chk(tg, "spec", AW'(spec), AW'(m_busy));
      chk(tg, "flush", AW'(flush), AW'(m_flush));
      chk(tg, "redir_valid", AW'(rvalid), AW'(m_flush));
      if (m_flush) chk("R8", "redir_addr", raddr, m_raddr);
      accept = v && nd && !m_busy;
      fl_n = m_busy && rv && (rt != m_ptaken);
      @(posedge clk);
      if (fl_n) m_raddr = m_alt;
      m_flush = fl_n;
      if (m_busy && rv) m_busy = 0;
      else if (accept) begin
         m_busy = 1;
         m_ptaken = (d == 1);
         m_alt = (d == 1) ? fa : ta;
      end
      @(negedge clk);
   endtask

   task automatic setb(input logic vv, input logic [1:0] kk, input logic n1,
                       input logic h1, input logic c1, input logic c2, input logic t1);
      v = vv; k = kk; ng = n1; h = h1; ck = c1; ct = c2; tr = t1;
      fa = $urandom; ta = $urandom;
   endtask

   task automatic setr(input logic a, input logic b);
      rv = a; rt = b;
   endtask

   initial begin
      setb(0, 0, 0, 0, 0, 0, 0);
      setr(0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step("R11");                       // R11 reset state
      // R1 all sign/hint combinations, mispredict when hint=1 (R8), else correct (R9)
      for (int i = 0; i < 4; i++) begin
         setb(1, 2'b00, i[1], i[0], 0, 0, 1); step("R6");
         setb(0, 0, 0, 0, 0, 0, 0); step("R6");
         setr(1, (i[1] ^ i[0]) ^ i[0]); step("R6");
         setr(0, 0); step(i[0] ? "R8" : "R9");
         step("R12");
      end
      // R2 register target ready
      for (int i = 0; i < 2; i++) begin
         setb(1, 2'b01, 0, i[0], 0, 0, 1); step("R6");
         setb(0, 0, 0, 0, 0, 0, 0); setr(1, i[0]); step("R9");
         setr(0, 0); step("R9");
      end
      // R3 register target not ready, any hint / condition
      for (int i = 0; i < 4; i++) begin
         setb(1, 2'b01, 0, i[0], i[1], 1, 0); step("R3");
      end
      setb(0, 0, 0, 0, 0, 0, 0); step("R3");
      // R4 unconditional kinds
      for (int i = 0; i < 4; i++) begin
         setb(1, {1'b1, i[1]}, i[0], i[1], 0, 0, 0); step("R4");
      end
      // R5 condition known
      for (int i = 0; i < 4; i++) begin
         setb(1, {1'b0, i[1]}, 1, 0, 1, i[0], 1); step("R5");
      end
      setb(0, 0, 0, 0, 0, 0, 0); step("R5");
      // R7 second branch stalled while busy, then mispredict a fall-through guess
      setb(1, 2'b00, 0, 0, 0, 0, 1); step("R6");
      setb(1, 2'b00, 1, 0, 0, 0, 1); step("R7");
      setb(1, 2'b01, 0, 1, 0, 0, 1); step("R7");
      setb(0, 0, 0, 0, 0, 0, 0); setr(1, 1); step("R7");
      setr(0, 0); step("R8");
      step("R12");
      // R10 outcome while idle
      setr(1, 1); step("R10");
      setr(1, 0); step("R10");
      setr(0, 0); step("R10");
      // mixed traffic against the model
      for (int i = 0; i < 3000; i++) begin
         setb($urandom_range(0, 1), 2'($urandom), 1'($urandom), 1'($urandom),
              ($urandom_range(0, 3) == 0), 1'($urandom), ($urandom_range(0, 3) != 0));
         setr(($urandom_range(0, 2) == 0), 1'($urandom));
         step("R6");
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule